// File: doc/BRIEF.md
# Synchronous Memory Port with Burst Address Counter

This block is one port of a synchronous static memory. Every access uses a registered address held in a built-in burst counter. On each clock edge, three active-low controls decide what the counter does. It can clear to zero, take the external address, keep its value, or step by one. The array is then read or written at the counter's new value. The counter follows its controls on every edge, whether or not the port is selected. A host can therefore present one address and then stream through consecutive words without driving the address bus again.

Two chip enables select the port: one is active low and one is active high. The read/write line picks the direction. An output enable gates the read data bus without waiting for a clock edge. The data bus is split into separate input, output and output-enable signals, so the block can be synthesized.

A mode pin is captured while reset is held. It chooses flow-through output, where the data appears right after the addressing edge. The other choice is pipelined output, where a register stage adds one cycle. In pipelined mode, changes of selection also take effect one cycle later. The array is a parameterized register file.

Top module: `burst_mem_port`

## Requirements
- R1: The port is selected only when `ce_n_i` is 0 and `ce_i` is 1. With any other combination on the access edge, that edge writes nothing, and the data bus is not driven (`rdata_oe_o` = 0) in the output cycle that belongs to the edge.
- R2: On a clock edge where the port is selected and `rw_i` = 0, `wdata_i` is written into the array at the counter value produced by that same edge. A write edge does not drive the data bus.
- R3: On a clock edge where the port is selected and `rw_i` = 1, the port drives `rdata_oe_o` = 1 and shows the stored word on `rdata_o` during its output cycle, provided `oe_n_i` = 0.
- R4: `oe_n_i` = 1 forces `rdata_oe_o` to 0 at once, with no clock edge needed. Returning it to 0 restores the drive at once.
- R5: In flow-through mode (captured mode = 0), the output cycle of an access edge is the clock cycle right after that edge. The data shown is the word at the counter value set by that edge.
- R6: In pipelined mode (captured mode = 1), the output cycle is one clock cycle later than in flow-through mode. This holds for both the start of a read and deselection.
- R7: When `cnt_clr_n_i` is 0 on an edge, the counter becomes 0. This takes priority over `cnt_ld_n_i` and `cnt_en_n_i`.
- R8: When `cnt_clr_n_i` is 1 and `cnt_ld_n_i` is 0, the counter takes the value of `addr_i`.
- R9: When `cnt_clr_n_i` and `cnt_ld_n_i` are both 1 and `cnt_en_n_i` is 1, the counter keeps its value, and `addr_i` has no effect.
- R10: When `cnt_clr_n_i` and `cnt_ld_n_i` are both 1 and `cnt_en_n_i` is 0, the counter goes up by one. From the top address 2^ADDR_W-1 it wraps to 0.
- R11: The counter follows R7 to R10 on every edge, whatever the state of the chip enables.
- R12: `pipe_mode_i` is captured only while `rst` is 1. Changing it outside reset does not change the output latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; captures the mode pin |
| pipe_mode_i | input | 1 | 1 = pipelined output, 0 = flow-through; captured during reset |
| ce_n_i | input | 1 | Active-low chip enable |
| ce_i | input | 1 | Active-high chip enable |
| rw_i | input | 1 | 1 = read, 0 = write |
| oe_n_i | input | 1 | Asynchronous active-low output enable |
| cnt_clr_n_i | input | 1 | Active-low counter clear |
| cnt_ld_n_i | input | 1 | Active-low address strobe (counter load) |
| cnt_en_n_i | input | 1 | Active-low count enable |
| addr_i | input | ADDR_W | External address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data (zero when not driven) |
| rdata_oe_o | output | 1 | Read data drive enable (tri-state control) |

## Verification
The counter cannot be observed directly, so its faults show up through the data. A wrong counter value, a lost wrap or a wrong control priority makes the next read return a word from the wrong address. That mismatch appears in the first output cycle after the bad edge: one cycle later in flow-through mode and two cycles later in pipelined mode. A wrong selection or latency register shows up in that same output cycle: the drive enable is on or off at the wrong time, or the word shown is one access out of step. Every address is preloaded with a distinct value before any read, so every wrong address is detectable.

// File: rtl/bmp_pkg.sv
package bmp_pkg;

    typedef enum logic [1:0] {
        CNT_CLEAR = 2'd0,
        CNT_LOAD  = 2'd1,
        CNT_HOLD  = 2'd2,
        CNT_STEP  = 2'd3
    } cnt_op_e;

    typedef enum logic {
        OUT_FLOW = 1'b0,
        OUT_PIPE = 1'b1
    } out_mode_e;

    typedef struct packed {
        logic sel;
        logic wr;
        logic rd;
    } access_t;

    // Clear beats load, load beats the enable.
    function automatic cnt_op_e decode_cnt(input logic clr_n, input logic ld_n,
                                           input logic en_n);
        cnt_op_e op;
        if (!clr_n)      op = CNT_CLEAR;
        else if (!ld_n)  op = CNT_LOAD;
        else if (en_n)   op = CNT_HOLD;
        else             op = CNT_STEP;
        return op;
    endfunction

    function automatic access_t decode_access(input logic ce_n, input logic ce,
                                              input logic rw);
        access_t a;
        a.sel = !ce_n && ce;
        a.wr  = a.sel && !rw;
        a.rd  = a.sel && rw;
        return a;
    endfunction

endpackage

// File: rtl/burst_counter.sv
module burst_counter
    import bmp_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  cnt_op_e           op_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic [ADDR_W-1:0] next_addr_o
);
    logic [ADDR_W-1:0] addr_q;

    always_comb begin
        unique case (op_i)
            CNT_CLEAR: next_addr_o = '0;
            CNT_LOAD:  next_addr_o = load_addr_i;
            CNT_HOLD:  next_addr_o = addr_q;
            default:   next_addr_o = addr_q + ADDR_W'(1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) addr_q <= '0;
        else     addr_q <= next_addr_o;
    end

    assign cur_addr_o = addr_q;
endmodule

// File: rtl/port_array.sv
module port_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
    end

    assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/out_stage.sv
module out_stage
    import bmp_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  out_mode_e         mode_i,
    input  logic              rd_req_i,
    input  logic [DATA_W-1:0] arr_data_i,
    input  logic              oe_n_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              dout_en_o
);
    logic              rd_q;
    logic              pipe_vld_q;
    logic [DATA_W-1:0] pipe_data_q;
    logic              drive;
    logic [DATA_W-1:0] data_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q       <= 1'b0;
            pipe_vld_q <= 1'b0;
        end else begin
            rd_q       <= rd_req_i;
            pipe_vld_q <= rd_q;
        end
        pipe_data_q <= arr_data_i;
    end

    always_comb begin
        if (mode_i == OUT_PIPE) begin
            drive    = pipe_vld_q;
            data_sel = pipe_data_q;
        end else begin
            drive    = rd_q;
            data_sel = arr_data_i;
        end
    end

    assign dout_en_o = drive && !oe_n_i;
    assign dout_o    = drive ? data_sel : '0;
endmodule

// File: rtl/burst_mem_port.sv
module burst_mem_port
    import bmp_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pipe_mode_i,
    input  logic              ce_n_i,
    input  logic              ce_i,
    input  logic              rw_i,
    input  logic              oe_n_i,
    input  logic              cnt_clr_n_i,
    input  logic              cnt_ld_n_i,
    input  logic              cnt_en_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rdata_oe_o
);
    out_mode_e         mode_q;
    cnt_op_e           cnt_op;
    access_t           acc;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] next_addr;
    logic [DATA_W-1:0] arr_data;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= out_mode_e'(pipe_mode_i);
    end

    assign cnt_op = decode_cnt(cnt_clr_n_i, cnt_ld_n_i, cnt_en_n_i);
    assign acc    = decode_access(ce_n_i, ce_i, rw_i);

    burst_counter #(.ADDR_W(ADDR_W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .op_i        (cnt_op),
        .load_addr_i (addr_i),
        .cur_addr_o  (cur_addr),
        .next_addr_o (next_addr)
    );

    port_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .clk       (clk),
        .wr_en_i   (acc.wr && !rst),
        .wr_addr_i (next_addr),
        .wr_data_i (wdata_i),
        .rd_addr_i (cur_addr),
        .rd_data_o (arr_data)
    );

    out_stage #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode_q),
        .rd_req_i   (acc.rd),
        .arr_data_i (arr_data),
        .oe_n_i     (oe_n_i),
        .dout_o     (rdata_o),
        .dout_en_o  (rdata_oe_o)
    );
endmodule

// File: rtl/burst_mem_port_chk.sv
module burst_mem_port_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n_i,
    input logic              ce_i,
    input logic              oe_n_i,
    input logic              cnt_clr_n_i,
    input logic              cnt_ld_n_i,
    input logic              cnt_en_n_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              pipe_q,
    input logic              rdata_oe_o
);
    logic sel;
    assign sel = !ce_n_i && ce_i;

    AST_CLEAR_FIRST: assert property (@(posedge clk) disable iff (rst)
        !cnt_clr_n_i |=> cur_addr == '0); // R7
    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (rst)
        cnt_clr_n_i && !cnt_ld_n_i |=> cur_addr == $past(addr_i)); // R8
    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (rst)
        cnt_clr_n_i && cnt_ld_n_i && cnt_en_n_i |=> $stable(cur_addr)); // R9
    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (rst)
        cnt_clr_n_i && cnt_ld_n_i && !cnt_en_n_i
        |=> cur_addr == ADDR_W'($past(cur_addr) + ADDR_W'(1))); // R10
    AST_OE_GATES: assert property (@(posedge clk) disable iff (rst)
        oe_n_i |-> !rdata_oe_o); // R4
    AST_DESEL_FLOW: assert property (@(posedge clk) disable iff (rst)
        !pipe_q && !$past(sel) |-> !rdata_oe_o); // R1
    AST_DESEL_PIPE: assert property (@(posedge clk) disable iff (rst)
        pipe_q && !$past(sel, 2) |-> !rdata_oe_o); // R6
endmodule

bind burst_mem_port burst_mem_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ce_n_i      (ce_n_i),
    .ce_i        (ce_i),
    .oe_n_i      (oe_n_i),
    .cnt_clr_n_i (cnt_clr_n_i),
    .cnt_ld_n_i  (cnt_ld_n_i),
    .cnt_en_n_i  (cnt_en_n_i),
    .addr_i      (addr_i),
    .cur_addr    (cur_addr),
    .pipe_q      (mode_q),
    .rdata_oe_o  (rdata_oe_o)
);

// File: tb/burst_mem_port_test.sv
`timescale 1ns/1ps
module burst_mem_port_test;
    localparam int AW = 6;
    localparam int DW = 9;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pipe_mode_i = 1'b0;
    logic ce_n_i = 1'b1, ce_i = 1'b0, rw_i = 1'b1, oe_n_i = 1'b0;
    logic cnt_clr_n_i = 1'b1, cnt_ld_n_i = 1'b1, cnt_en_n_i = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] wdata_i = '0;
    logic [DW-1:0] rdata_o;
    logic rdata_oe_o;

    always #2.5 clk = ~clk;

    burst_mem_port #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .pipe_mode_i(pipe_mode_i),
        .ce_n_i(ce_n_i), .ce_i(ce_i), .rw_i(rw_i), .oe_n_i(oe_n_i),
        .cnt_clr_n_i(cnt_clr_n_i), .cnt_ld_n_i(cnt_ld_n_i), .cnt_en_n_i(cnt_en_n_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .rdata_oe_o(rdata_oe_o)
    );

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // bench reference state
    logic [DW-1:0] m_mem [DEPTH];
    logic [AW-1:0] m_cnt;
    logic m_rdq, m_pv, m_mode;
    logic [DW-1:0] m_pd;

    function automatic logic [AW-1:0] next_cnt(logic [AW-1:0] c);
        if (!cnt_clr_n_i) return '0;
        if (!cnt_ld_n_i)  return addr_i;
        if (cnt_en_n_i)   return c;
        return c + AW'(1);
    endfunction

    function automatic logic [DW-1:0] pattern(int i);
        return DW'((i * 37 + 11) ^ (i << 3));
    endfunction

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_outputs(string tag);
        logic drv, eoe;
        logic [DW-1:0] edata;
        drv   = m_mode ? m_pv : m_rdq;
        edata = m_mode ? m_pd : m_mem[m_cnt];
        eoe   = drv && !oe_n_i;
        check(tag, DW'(rdata_oe_o), DW'(eoe));
        if (eoe) check(tag, rdata_o, edata);
    endtask

    // one clock: inputs already driven at a falling edge
    task automatic step(string tag);
        logic sel;
        @(posedge clk);
        sel   = !ce_n_i && ce_i;
        m_pv  = m_rdq;
        m_pd  = m_mem[m_cnt];
        m_cnt = next_cnt(m_cnt);
        if (sel && !rw_i) m_mem[m_cnt] = wdata_i;
        m_rdq = sel && rw_i;
        @(negedge clk);
        check_outputs(tag);
    endtask

    task automatic do_reset(logic mode);
        @(negedge clk);
        rst = 1'b1;
        pipe_mode_i = mode;
        ce_n_i = 1'b1; ce_i = 1'b0; oe_n_i = 1'b0;
        cnt_clr_n_i = 1'b1; cnt_ld_n_i = 1'b1; cnt_en_n_i = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_cnt = '0; m_rdq = 1'b0; m_pv = 1'b0; m_mode = mode;
        check_outputs("R1");
        check("R1", DW'(rdata_oe_o), '0);
    endtask

    task automatic set_ctl(logic sel, logic rw, logic clr_n, logic ld_n, logic en_n,
                           logic [AW-1:0] a);
        ce_n_i = !sel; ce_i = sel; rw_i = rw;
        cnt_clr_n_i = clr_n; cnt_ld_n_i = ld_n; cnt_en_n_i = en_n; addr_i = a;
    endtask

    task automatic random_cycles(int n);
        for (int k = 0; k < n; k++) begin
            ce_n_i      = ($urandom % 4) == 0;
            ce_i        = ($urandom % 5) != 0;
            rw_i        = $urandom % 2;
            oe_n_i      = ($urandom % 6) == 0;
            cnt_clr_n_i = ($urandom % 10) != 0;
            cnt_ld_n_i  = ($urandom % 3) != 0;
            cnt_en_n_i  = $urandom % 2;
            addr_i      = AW'($urandom);
            wdata_i     = DW'($urandom);
            step(m_mode ? "R6" : "R5");
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        do_reset(1'b0);

        // preload every word through the load path (R2)
        for (int i = 0; i < DEPTH; i++) begin
            set_ctl(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, AW'(i));
            wdata_i = pattern(i);
            step("R2");
        end
        // R8: load and read
        set_ctl(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 6'd5);
        step("R8");
        check("R8", rdata_o, pattern(5));
        // R9: hold ignores address
        set_ctl(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 6'd40);
        step("R9");
        check("R9", rdata_o, pattern(5));
        // R10: increment and wrap
        set_ctl(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 6'd0);
        step("R10");
        check("R10", rdata_o, pattern(6));
        set_ctl(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 6'd63);
        step("R10");
        set_ctl(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 6'd17);
        step("R10");
        check("R10", rdata_o, pattern(0));
        // R7: clear beats load and enable
        set_ctl(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 6'd20);
        step("R8");
        set_ctl(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'd9);
        step("R7");
        check("R7", rdata_o, pattern(0));
        // R11: counter steps while deselected
        for (int k = 0; k < 3; k++) begin
            set_ctl(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 6'd30);
            step("R1");
        end
        set_ctl(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 6'd30);
        step("R11");
        check("R11", rdata_o, pattern(3));
        // R4 / R3: output enable acts without a clock edge
        #1 oe_n_i = 1'b1;
        #0.5 check("R4", DW'(rdata_oe_o), '0);
        oe_n_i = 1'b0;
        #0.5 check("R3", DW'(rdata_oe_o), 1);
        @(negedge clk);
        // R1: only ce_n=0 with ce=1 writes
        set_ctl(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 6'd12);
        ce_i = 1'b0; wdata_i = 9'h1AA;
        step("R1");
        set_ctl(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 6'd0);
        step("R1");
        check("R1", rdata_o, pattern(12));

        random_cycles(600);

        // pipelined phase
        do_reset(1'b1);
        pipe_mode_i = 1'b0; // R12: must be ignored now
        set_ctl(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 6'd7);
        step("R6");
        check("R6", DW'(rdata_oe_o), '0);
        set_ctl(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 6'd0);
        step("R12");
        check("R12", DW'(rdata_oe_o), 1);
        check("R12", rdata_o, m_mem[7]);
        step("R6");
        check("R6", DW'(rdata_oe_o), '0);
        random_cycles(600);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule